// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block tells a DDR2-class memory controller when auto-refresh commands are due and when other commands may follow them. A free-running interval timer adds one unit of refresh debt each time it expires. The interval is about 7.8 µs at normal temperature and about 3.9 µs at high temperature. The block asks for a refresh whenever debt is owed and the command path is idle. This lets the controller postpone refreshes while traffic is heavy. Once eight refreshes are owed, the request becomes urgent: it is raised even while the command path is busy, and the controller must serve it before anything else.

The controller answers a request with a one-cycle grant. Each grant is taken as a refresh command on the bus. The block then lowers its activate-ready flag for the refresh cycle time (105 ns rounded up to whole clocks). A self-refresh exit strobe clears the debt and restarts the interval. It also starts two separate waits:
- activate and other non-read commands wait for the refresh cycle time plus 10 ns;
- reads wait a fixed 200 clock cycles.

Every nanosecond figure becomes a cycle count at elaboration, rounded up, from a clock-period parameter in picoseconds.

Top module: `dram_refresh_sched`

## Requirements
- R1: While rst_n is sampled low, the block sets debt to 0, ref_req and ref_urgent to 0, and act_ok and rd_ok to 1.
- R2: At normal temperature the debt grows by one every ceil(7 800 000 ps / CLK_PS) cycles (3120 at 2500 ps). The first increment happens at the 3120th rising edge after the last reset edge.
- R3: temp_hot is sampled only when the interval reloads. If it is high then, the next interval is ceil(3 900 000 ps / CLK_PS) cycles (1560). Changing temp_hot in the middle of an interval does not alter that interval.
- R4: ref_req is 1 exactly when debt is nonzero, act_ok is 1, and either cmd_busy is 0 or ref_urgent is 1.
- R5: A ref_grant sampled while ref_req is 1 counts as a refresh command and lowers debt by one. An interval expiry in the same cycle cancels the decrement.
- R6: ref_urgent is 1 exactly when debt equals 8. While it is 1, ref_req is raised regardless of cmd_busy, provided act_ok is 1.
- R7: debt never exceeds 8. An interval expiry while debt is 8 and no refresh is granted leaves debt at 8.
- R8: After a granted refresh at edge e, act_ok is 0 until the edge e+ceil(105 000 ps / CLK_PS)−1 has passed. The next activate or refresh can therefore be taken no earlier than edge e+42.
- R9: After sr_exit is sampled at edge e, debt becomes 0 and the interval restarts. act_ok returns only after edge e+ceil(115 000 ps / CLK_PS)−1 (first usable edge e+46). rd_ok returns only after edge e+199 (first usable edge e+200).
- R10: rd_ok is never 1 while act_ok is 0.
- R11: A ref_grant sampled while ref_req is 0 has no effect: debt, act_ok and the recovery window are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period CLK_PS |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_hot | input | 1 | 1 = device above 85 °C; picks the short interval at the next reload |
| cmd_busy | input | 1 | Command path has other traffic this cycle |
| ref_grant | input | 1 | Controller issues the requested refresh at this edge |
| sr_exit | input | 1 | One-cycle strobe: device left self-refresh at this edge |
| ref_req | output | 1 | A refresh should be issued |
| ref_urgent | output | 1 | Postponement limit reached; refresh comes before all traffic |
| act_ok | output | 1 | Activate, refresh and other non-read commands allowed |
| rd_ok | output | 1 | Read commands allowed |
| debt | output | $clog2(MAX_DEBT+1) | Number of refreshes currently owed |

## Verification
The assertions assume the following about the inputs:
- ref_grant is a single-cycle pulse, asserted only while ref_req is high. Any other grant is discarded (R11).
- sr_exit never coincides with a grant.
- The controller does not let debt reach eight and then sit through another interval unless it means to test the saturation case.

The stimulus drives every input at the falling edge. It holds cmd_busy high long enough to push the debt to its ceiling on purpose. It pulses sr_exit only when no grant is pending. Grants come either from a one-off manual pulse or from an automatic policy that grants exactly when ref_req is observed high. The one exception is a deliberately illegal grant, aimed at R11.

// File: rtl/dram_ref_pkg.sv
// Package dram_ref_pkg
// Shared helpers for the refresh scheduler.
// Assumes every time is given in whole picoseconds that fit in 32 bits.
package dram_ref_pkg;

    // Convert a duration in ps to clock cycles, rounding up.
    function automatic int unsigned ps_to_ck(input int unsigned ps, input int unsigned clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
// Module ref_interval_timer
// Free-running refresh interval timer. Pulses tick for one cycle when the
// interval runs out. It then reloads with the short or long length, picked by
// temp_hot at that moment. restart reloads it at once.
// Assumes both lengths are at least 2 cycles.
module ref_interval_timer #(
    parameter int unsigned NORM_CK = 3120,
    parameter int unsigned HOT_CK  = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hot,
    input  logic restart,
    output logic tick
);
    localparam int unsigned MAXI = (NORM_CK > HOT_CK) ? NORM_CK : HOT_CK;
    localparam int unsigned TW   = $clog2(MAXI);

    logic [TW-1:0] tmr;
    logic [TW-1:0] reload_val;

    // Choose the reload length from the temperature range.
    always_comb begin
        reload_val = temp_hot ? TW'(HOT_CK - 1) : TW'(NORM_CK - 1);
    end

    // Count down, reloading on expiry or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= TW'(NORM_CK - 1);
        end else if (restart || tmr == '0) begin
            tmr <= reload_val;
        end else begin
            tmr <= tmr - TW'(1);
        end
    end

    assign tick = (tmr == '0);

    // An expiry is never followed directly by another one.
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/ref_debt_ctr.sv
// Module ref_debt_ctr
// Saturating count of owed refreshes. An expiry adds one and a served refresh
// removes one; both together leave the count unchanged. clear empties it.
// Assumes served is only asserted while the count is nonzero.
module ref_debt_ctr #(
    parameter int unsigned MAX_DEBT = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic                            served,
    input  logic                            clear,
    output logic [$clog2(MAX_DEBT+1)-1:0]   debt,
    output logic                            urgent
);
    localparam int unsigned DW = $clog2(MAX_DEBT + 1);

    // Track debt with saturation at the postponement ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            debt <= '0;
        end else if (tick && !served) begin
            if (debt != DW'(MAX_DEBT)) begin
                debt <= debt + DW'(1);
            end
        end else if (served && !tick) begin
            debt <= debt - DW'(1);
        end
    end

    assign urgent = (debt == DW'(MAX_DEBT));

    // Debt stays within the ceiling.
    assert_debt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DW'(MAX_DEBT));

    // Urgency persists until a refresh is served or debt is cleared.
    assert_urgent_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent && !served && !clear) |=> urgent);

endmodule

// File: rtl/ref_wait_ctr.sv
// Module ref_wait_ctr
// One-shot wait window. start opens a window of WAIT_CK cycles, counted from
// the starting edge. idle is high again once a command may be taken at the
// next edge. A new start restarts the window.
module ref_wait_ctr #(
    parameter int unsigned WAIT_CK = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle
);
    localparam int unsigned CW   = $clog2(WAIT_CK + 1);
    localparam int unsigned LOAD = (WAIT_CK > 1) ? WAIT_CK - 1 : 0;

    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(LOAD);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign idle = (cnt == '0);

    generate
        if (WAIT_CK > 1) begin : g_chk
            // A started window is closed on the following cycle.
            assert_window_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> !idle);
        end
    endgenerate

endmodule

// File: rtl/dram_refresh_sched.sv
// Module dram_refresh_sched
// Top of the refresh scheduler. It combines the interval timer, the debt
// counter and three wait windows: refresh recovery, self-refresh exit to
// non-read commands, and self-refresh exit to reads. From these it derives
// the request and ready flags. All cycle counts come from CLK_PS at
// elaboration.
// Assumes ref_grant is a one-cycle pulse and does not coincide with sr_exit.
module dram_refresh_sched #(
    parameter int unsigned CLK_PS       = 2500,
    parameter int unsigned REFI_NORM_PS = 7_800_000,
    parameter int unsigned REFI_HOT_PS  = 3_900_000,
    parameter int unsigned RFC_PS       = 105_000,
    parameter int unsigned XS_EXTRA_PS  = 10_000,
    parameter int unsigned XS_READ_CK   = 200,
    parameter int unsigned MAX_DEBT     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            temp_hot,
    input  logic                            cmd_busy,
    input  logic                            ref_grant,
    input  logic                            sr_exit,
    output logic                            ref_req,
    output logic                            ref_urgent,
    output logic                            act_ok,
    output logic                            rd_ok,
    output logic [$clog2(MAX_DEBT+1)-1:0]   debt
);
    import dram_ref_pkg::*;

    localparam int unsigned NORM_CK = ps_to_ck(REFI_NORM_PS, CLK_PS);
    localparam int unsigned HOT_CK  = ps_to_ck(REFI_HOT_PS, CLK_PS);
    localparam int unsigned RFC_CK  = ps_to_ck(RFC_PS, CLK_PS);
    localparam int unsigned XSNR_CK = ps_to_ck(RFC_PS + XS_EXTRA_PS, CLK_PS);

    logic tick;
    logic served;
    logic rfc_idle;
    logic nr_idle;
    logic rd_idle;

    // A grant only counts while a refresh is actually requested.
    assign served = ref_grant & ref_req;

    ref_interval_timer #(
        .NORM_CK (NORM_CK),
        .HOT_CK  (HOT_CK)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .temp_hot (temp_hot),
        .restart  (sr_exit),
        .tick     (tick)
    );

    ref_debt_ctr #(
        .MAX_DEBT (MAX_DEBT)
    ) debt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .served (served),
        .clear  (sr_exit),
        .debt   (debt),
        .urgent (ref_urgent)
    );

    ref_wait_ctr #(.WAIT_CK (RFC_CK)) rfc_win_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (served),
        .idle  (rfc_idle)
    );

    ref_wait_ctr #(.WAIT_CK (XSNR_CK)) xsnr_win_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sr_exit),
        .idle  (nr_idle)
    );

    ref_wait_ctr #(.WAIT_CK (XS_READ_CK)) xsrd_win_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sr_exit),
        .idle  (rd_idle)
    );

    // Derive ready flags and the refresh request.
    always_comb begin
        act_ok  = rfc_idle & nr_idle;
        rd_ok   = act_ok & rd_idle;
        ref_req = (debt != '0) & act_ok & (~cmd_busy | ref_urgent);
    end

    generate
        if (RFC_CK > 1) begin : g_rfc_chk
            // No activate or refresh right after a served refresh.
            assert_rfc_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
                served |=> !act_ok);
        end
        if (XS_READ_CK > 1) begin : g_xs_chk
            // Reads are held off right after leaving self-refresh.
            assert_xs_read_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
                sr_exit |=> (!rd_ok && debt == '0));
        end
    endgenerate

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
// Bench for dram_refresh_sched: cycle-by-cycle comparison against an
// arithmetic model built from the requirements, plus targeted corner checks.
module dram_refresh_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_PS     = 2500;
    localparam int NORM = (7_800_000 + CLK_PS - 1) / CLK_PS;
    localparam int HOT  = (3_900_000 + CLK_PS - 1) / CLK_PS;
    localparam int RFC  = (105_000 + CLK_PS - 1) / CLK_PS;
    localparam int XSNR = (115_000 + CLK_PS - 1) / CLK_PS;
    localparam int XSRD = 200;
    localparam int MAXD = 8;
    localparam int IDLE_AGE = 1_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic temp_hot = 1'b0;
    logic cmd_busy = 1'b1;
    logic ref_grant = 1'b0;
    logic sr_exit = 1'b0;
    logic ref_req, ref_urgent, act_ok, rd_ok;
    logic [3:0] debt;

    int checks = 0;
    int failures = 0;
    bit chk_on = 1'b0;
    bit auto_en = 1'b0;
    bit done = 1'b0;

    // Requirement-level model state
    int m_debt, m_since, m_intv, m_rfc_age, m_nr_age, m_rd_age;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_sched #(.CLK_PS(CLK_PS)) dut_i (
        .clk(clk), .rst_n(rst_n), .temp_hot(temp_hot), .cmd_busy(cmd_busy),
        .ref_grant(ref_grant), .sr_exit(sr_exit), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .act_ok(act_ok), .rd_ok(rd_ok), .debt(debt)
    );

    function automatic bit m_act();
        return (m_rfc_age >= RFC - 1) && (m_nr_age >= XSNR - 1);
    endfunction
    function automatic bit m_rd();
        return m_act() && (m_rd_age >= XSRD - 1);
    endfunction
    function automatic bit m_urg();
        return m_debt == MAXD;
    endfunction
    function automatic bit m_req();
        return (m_debt != 0) && m_act() && (!cmd_busy || m_urg());
    endfunction
    function automatic int age_inc(input int a);
        return (a >= IDLE_AGE) ? a : a + 1;
    endfunction

    // Advance the model at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_debt = 0; m_since = 0; m_intv = NORM;
            m_rfc_age = IDLE_AGE; m_nr_age = IDLE_AGE; m_rd_age = IDLE_AGE;
        end else begin
            bit served, tk;
            served = ref_grant && m_req();
            tk = 1'b0;
            if (m_since + 1 == m_intv) begin
                tk = 1'b1; m_since = 0; m_intv = temp_hot ? HOT : NORM;
            end else begin
                m_since = m_since + 1;
            end
            m_rfc_age = age_inc(m_rfc_age);
            m_nr_age  = age_inc(m_nr_age);
            m_rd_age  = age_inc(m_rd_age);
            if (served) m_rfc_age = 0;
            if (sr_exit) begin
                m_debt = 0; m_since = 0; m_intv = temp_hot ? HOT : NORM;
                m_nr_age = 0; m_rd_age = 0;
            end else if (tk && !served) begin
                if (m_debt < MAXD) m_debt = m_debt + 1;
            end else if (served && !tk) begin
                m_debt = m_debt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: at the falling edge compare outputs, then set inputs.
    task automatic cyc();
        @(negedge clk);
        if (chk_on) begin
            check(int'(debt) == m_debt, "R2", "debt", int'(debt), m_debt);
            check(ref_urgent == m_urg(), "R6", "ref_urgent", ref_urgent, m_urg());
            check(ref_req == m_req(), "R4", "ref_req", ref_req, m_req());
            check(act_ok == m_act(), "R8", "act_ok", act_ok, m_act());
            check(rd_ok == m_rd(), "R9", "rd_ok", rd_ok, m_rd());
            check(!(rd_ok && !act_ok), "R10", "rd_ok_without_act_ok", rd_ok, 0);
            check(int'(debt) <= MAXD, "R7", "debt_ceiling", int'(debt), MAXD);
        end
        sr_exit = 1'b0;
        ref_grant = auto_en ? ref_req : 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (60_000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) cyc();
        chk_on = 1'b1;
        cyc();
        check(debt == 0 && !ref_req && !ref_urgent && act_ok && rd_ok, "R1", "reset_state",
              {debt, ref_req, ref_urgent, act_ok, rd_ok}, 3);
        rst_n = 1'b1;

        // R2, R3: busy path, normal intervals, temp change mid-interval
        for (int i = 0; i < 7000; i++) cyc();
        temp_hot = 1'b1;
        for (int i = 0; i < 11800; i++) cyc();
        // R6, R7: ceiling reached and held while busy
        check(debt == 4'(MAXD) && ref_urgent && ref_req, "R6", "urgent_while_busy",
              int'(debt), MAXD);

        // R8, R5: one granted refresh, then its recovery window
        ref_grant = 1'b1;
        cyc();
        check(int'(debt) == MAXD - 1 && !act_ok, "R5", "grant_decrements", int'(debt), MAXD - 1);
        cmd_busy = 1'b0;
        for (int i = 0; i < 50; i++) cyc();
        auto_en = 1'b1;
        for (int i = 0; i < 600; i++) cyc();
        check(debt == 0, "R5", "drained", int'(debt), 0);

        // R11: grant without a request is ignored
        auto_en = 1'b0;
        cmd_busy = 1'b1;
        cyc();
        ref_grant = 1'b1;
        cyc();
        check(debt == 0 && act_ok, "R11", "stray_grant_ignored", {debt, act_ok}, 1);

        // R3: back to normal range mid-interval
        temp_hot = 1'b0;
        for (int i = 0; i < 3500; i++) cyc();

        // R9: self-refresh exit waits and debt clear
        sr_exit = 1'b1;
        cyc();
        check(debt == 0 && !act_ok && !rd_ok, "R9", "sr_exit_entry", {debt, act_ok, rd_ok}, 0);
        for (int i = 0; i < 250; i++) cyc();
        check(rd_ok && act_ok, "R9", "sr_exit_release", {act_ok, rd_ok}, 3);

        // Mixed traffic with the automatic grant policy
        auto_en = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            cmd_busy = (i % 7) < 3;
            cyc();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule